// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Unit

The unit holds a bank of sixteen byte-wide mailboxes that a host-bus agent and a local-bus agent share through two identical register-access ports. Either agent can read or write any mailbox. A mailbox access can ring a doorbell: each of the four access kinds (host read, host write, local read, local write) has its own enable mask with one bit per mailbox. When the mask bit is set, the access latches a request bit in a status register.

Requests raised by host-side accesses drive the local interrupt line. Requests raised by local-side accesses drive the host interrupt line. Software clears latched requests by writing ones to the status registers. An interrupt line stays high until every enabled latched request that feeds it has been cleared.

Both ports decode one address map. Addresses 0 to 15 select mailbox 0 to 15. Address 16 is the host-read enable mask, 17 the host-write enable mask, 18 the local-read enable mask and 19 the local-write enable mask. Address 20 is the read status of host-originated events and 21 the read status of local-originated events. Address 22 is the write status of host-originated events and 23 the write status of local-originated events. In every mask and status register, bit i belongs to mailbox i. Reads are combinational: `*_rdata` reflects the current state in the same cycle as the address.

Top module: `mbox_doorbell`

## Requirements
- R1: Each port writes mailbox i (address i, 0 to 15) on a cycle with `en`=1 and `we`=1, storing `wdata[7:0]`. Reading address i returns the stored byte in bits 7:0 and zero in bits 15:8.
- R2: The four enable masks at addresses 16 to 19 are written with the full 16-bit `wdata` and read back unchanged.
- R3: After reset all mailboxes, enable masks and status registers read zero, and both interrupt outputs are low.
- R4: An access to mailbox i sets bit i of a status register only when the matching enable bit was 1 in that cycle. Host reads set address 20, local reads address 21, host writes address 22 and local writes address 23. Accesses to addresses 16 and above raise no events.
- R5: A write to a status address clears the bits where `wdata` is 1 and leaves the bits where `wdata` is 0. Both ports can clear.
- R6: `irq_local` is the OR over i of (bit i of address 20 AND host-read enable bit i) OR (bit i of address 22 AND host-write enable bit i). `irq_host` is the same over addresses 21 and 23 with the local masks.
- R7: An interrupt output that is high stays high until the status bits or enable bits feeding it are cleared.
- R8: When a status bit is set and cleared in the same cycle, it ends the cycle at 1.
- R9: When both ports write the same mailbox or the same enable mask in one cycle, the host data is stored. Both mailbox write events are latched if enabled.
- R10: Addresses 24 to 31 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_en | input | 1 | Host port access strobe |
| h_we | input | 1 | Host port write (1) or read (0) |
| h_addr | input | 5 | Host port register address |
| h_wdata | input | 16 | Host port write data |
| h_rdata | output | 16 | Host port read data |
| l_en | input | 1 | Local port access strobe |
| l_we | input | 1 | Local port write (1) or read (0) |
| l_addr | input | 5 | Local port register address |
| l_wdata | input | 16 | Local port write data |
| l_rdata | output | 16 | Local port read data |
| irq_local | output | 1 | Interrupt to the local side from host-originated requests |
| irq_host | output | 1 | Interrupt to the host side from local-originated requests |

## Verification
The bench builds the unit with its defaults: sixteen mailboxes, eight data bits and a five-bit address. This covers the whole map including the unused addresses 24 to 31. At this size, a random phase that mixes both ports regularly produces same-cycle collisions on one mailbox, on one enable mask, and between a set and a clear of one status bit. Directed steps first pin down each of those cases.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int NMB = 16,
  parameter int MBW = 8,
  localparam int DW = NMB,
  localparam int AW = $clog2(NMB + 8),
  localparam int IW = $clog2(NMB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_en,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          irq_local,
  output logic          irq_host
);
  localparam logic [AW-1:0] A_EHR = AW'(NMB);
  localparam logic [AW-1:0] A_EHW = AW'(NMB + 1);
  localparam logic [AW-1:0] A_ELR = AW'(NMB + 2);
  localparam logic [AW-1:0] A_ELW = AW'(NMB + 3);
  localparam logic [AW-1:0] A_RSH = AW'(NMB + 4);
  localparam logic [AW-1:0] A_RSL = AW'(NMB + 5);
  localparam logic [AW-1:0] A_WSH = AW'(NMB + 6);
  localparam logic [AW-1:0] A_WSL = AW'(NMB + 7);

  logic [MBW-1:0] mbox [NMB];
  logic [DW-1:0] en_hr, en_hw, en_lr, en_lw;
  logic [DW-1:0] st_rh, st_rl, st_wh, st_wl;

  wire h_wr = h_en && h_we;
  wire l_wr = l_en && l_we;
  wire h_mb = h_en && (h_addr < AW'(NMB));
  wire l_mb = l_en && (l_addr < AW'(NMB));
  wire [DW-1:0] h_sel = h_mb ? (DW'(1) << h_addr[IW-1:0]) : '0;
  wire [DW-1:0] l_sel = l_mb ? (DW'(1) << l_addr[IW-1:0]) : '0;

  wire [DW-1:0] set_rh = h_we ? '0 : (h_sel & en_hr);
  wire [DW-1:0] set_wh = h_we ? (h_sel & en_hw) : '0;
  wire [DW-1:0] set_rl = l_we ? '0 : (l_sel & en_lr);
  wire [DW-1:0] set_wl = l_we ? (l_sel & en_lw) : '0;

  function automatic logic [DW-1:0] clr_of(input logic [AW-1:0] a,
      input logic hw, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
      input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld);
    return ((hw && ha == a) ? hd : '0) | ((lw && la == a) ? ld : '0);
  endfunction

  wire [DW-1:0] clr_rh = clr_of(A_RSH, h_wr, h_addr, h_wdata, l_wr, l_addr, l_wdata);
  wire [DW-1:0] clr_rl = clr_of(A_RSL, h_wr, h_addr, h_wdata, l_wr, l_addr, l_wdata);
  wire [DW-1:0] clr_wh = clr_of(A_WSH, h_wr, h_addr, h_wdata, l_wr, l_addr, l_wdata);
  wire [DW-1:0] clr_wl = clr_of(A_WSL, h_wr, h_addr, h_wdata, l_wr, l_addr, l_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NMB; i++) mbox[i] <= '0;
    end else begin
      for (int i = 0; i < NMB; i++)
        if (h_wr && h_sel[i]) mbox[i] <= h_wdata[MBW-1:0];
        else if (l_wr && l_sel[i]) mbox[i] <= l_wdata[MBW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_hr <= '0; en_hw <= '0; en_lr <= '0; en_lw <= '0;
    end else begin
      if (h_wr && h_addr == A_EHR) en_hr <= h_wdata; else if (l_wr && l_addr == A_EHR) en_hr <= l_wdata;
      if (h_wr && h_addr == A_EHW) en_hw <= h_wdata; else if (l_wr && l_addr == A_EHW) en_hw <= l_wdata;
      if (h_wr && h_addr == A_ELR) en_lr <= h_wdata; else if (l_wr && l_addr == A_ELR) en_lr <= l_wdata;
      if (h_wr && h_addr == A_ELW) en_lw <= h_wdata; else if (l_wr && l_addr == A_ELW) en_lw <= l_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rh <= '0; st_rl <= '0; st_wh <= '0; st_wl <= '0;
    end else begin
      st_rh <= (st_rh & ~clr_rh) | set_rh;
      st_rl <= (st_rl & ~clr_rl) | set_rl;
      st_wh <= (st_wh & ~clr_wh) | set_wh;
      st_wl <= (st_wl & ~clr_wl) | set_wl;
    end
  end

  function automatic logic [DW-1:0] rd_of(input logic [AW-1:0] a);
    if (a < AW'(NMB)) return DW'(mbox[a[IW-1:0]]);
    case (a)
      A_EHR: return en_hr;
      A_EHW: return en_hw;
      A_ELR: return en_lr;
      A_ELW: return en_lw;
      A_RSH: return st_rh;
      A_RSL: return st_rl;
      A_WSH: return st_wh;
      A_WSL: return st_wl;
      default: return '0;
    endcase
  endfunction

  assign h_rdata = rd_of(h_addr);
  assign l_rdata = rd_of(l_addr);

  assign irq_local = |((st_rh & en_hr) | (st_wh & en_hw));
  assign irq_host  = |((st_rl & en_lr) | (st_wl & en_lw));

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_wh & ~$past(st_wh) & ~$past(en_hw)) == '0) && ((st_rl & ~$past(st_rl) & ~$past(en_lr)) == '0)); // R4
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_rh) & ~$past(clr_rh) & ~st_rh) == '0) && (($past(st_wl) & ~$past(clr_wl) & ~st_wl) == '0)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_rh | set_wh) & ~(st_rh | st_wh)) == '0)); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_local && clr_rh == '0 && clr_wh == '0 && !(h_wr && (h_addr == A_EHR || h_addr == A_EHW))
      && !(l_wr && (l_addr == A_EHR || l_addr == A_EHW))) |=> irq_local); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lr == '0 && en_lw == '0) |-> !irq_host); // R6
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && l_wr && h_mb && h_addr == l_addr) |=> (h_rdata == $past(DW'(h_wdata[MBW-1:0])) || h_addr != $past(h_addr))); // R9
endmodule

// File: tb/sim_mbox_doorbell.sv
module sim_mbox_doorbell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_en = 0, h_we = 0, l_en = 0, l_we = 0;
  logic [4:0] h_addr = 0, l_addr = 0;
  logic [15:0] h_wdata = 0, l_wdata = 0;
  logic [15:0] h_rdata, l_rdata;
  logic irq_local, irq_host;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mbox_doorbell u0 (.clk(clk), .rst_n(rst_n),
    .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .irq_local(irq_local), .irq_host(irq_host));

  // reference model: reg index 0..15 mailboxes, 16..23 masks and status
  int m [24];

  function automatic int mrd(input int a);
    return (a < 24) ? m[a] : 0;
  endfunction

  function automatic bit m_irq_local();
    return ((m[20] & m[16]) | (m[22] & m[17])) != 0;
  endfunction

  function automatic bit m_irq_host();
    return ((m[21] & m[18]) | (m[23] & m[19])) != 0;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic model_update(input bit he, input bit hw, input int ha, input int hd,
                              input bit le, input bit lw, input int la, input int ld);
    int n [24];
    n = m;
    for (int r = 20; r < 24; r++) begin
      int c = 0;
      if (he && hw && ha == r) c |= hd;
      if (le && lw && la == r) c |= ld;
      n[r] = m[r] & ~c & 16'hFFFF;
    end
    if (he && ha < 16) begin
      if (hw) begin if ((m[17] >> ha) & 1) n[22] |= (1 << ha); end
      else    begin if ((m[16] >> ha) & 1) n[20] |= (1 << ha); end
    end
    if (le && la < 16) begin
      if (lw) begin if ((m[19] >> la) & 1) n[23] |= (1 << la); end
      else    begin if ((m[18] >> la) & 1) n[21] |= (1 << la); end
    end
    if (le && lw && la < 16) n[la] = ld & 8'hFF;
    if (le && lw && la >= 16 && la < 20) n[la] = ld;
    if (he && hw && ha < 16) n[ha] = hd & 8'hFF;
    if (he && hw && ha >= 16 && ha < 20) n[ha] = hd;
    m = n;
  endtask

  task automatic step(input string tag, input bit he, input bit hw, input int ha, input int hd,
                      input bit le, input bit lw, input int la, input int ld);
    h_en = he; h_we = hw; h_addr = 5'(ha); h_wdata = 16'(hd);
    l_en = le; l_we = lw; l_addr = 5'(la); l_wdata = 16'(ld);
    #2;
    chk(tag, "h_rdata", int'(h_rdata), mrd(ha));
    chk(tag, "l_rdata", int'(l_rdata), mrd(la));
    chk(tag, "irq_local", int'(irq_local), int'(m_irq_local()));
    chk(tag, "irq_host", int'(irq_host), int'(m_irq_host()));
    @(posedge clk);
    model_update(he, hw, ha, hd & 16'hFFFF, le, lw, la, ld & 16'hFFFF);
    @(negedge clk);
  endtask

  task automatic hrd(input string tag, input int a); step(tag, 1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic hwr(input string tag, input int a, input int d); step(tag, 1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic lwr(input string tag, input int a, input int d); step(tag, 0, 0, 0, 0, 1, 1, a, d); endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 24; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: reset state across whole map
    for (int a = 0; a < 24; a++) step("R3", 1, 0, a, 0, 1, 0, 23 - a, 0);
    // R1: mailbox write/read both directions, upper bits zero
    hwr("R1", 3, 16'hFFA5);
    step("R1", 0, 0, 0, 0, 1, 0, 3, 0);
    lwr("R1", 7, 16'h1234);
    hrd("R1", 7);
    // R2: enable masks
    hwr("R2", 16, 16'h00F0);
    lwr("R2", 17, 16'h0F0F);
    hwr("R2", 18, 16'h8001);
    lwr("R2", 19, 16'hFFFF);
    for (int a = 16; a < 20; a++) hrd("R2", a);
    // R4: enabled and disabled accesses
    hrd("R4", 4);
    hrd("R4", 2);
    hwr("R4", 0, 8'h11);
    hwr("R4", 1, 8'h22);
    step("R4", 0, 0, 0, 0, 1, 0, 15, 0);
    step("R4", 0, 0, 0, 0, 1, 0, 14, 0);
    lwr("R4", 9, 8'h33);
    for (int a = 20; a < 24; a++) hrd("R4", a);
    // R5/R7: zeros keep, ones clear, irq holds until last bit gone
    hwr("R5", 20, 16'h0000);
    hrd("R7", 20);
    hwr("R5", 20, 16'h0010);
    lwr("R5", 22, 16'h0001);
    hrd("R7", 22);
    lwr("R5", 21, 16'h8000);
    lwr("R5", 23, 16'h0200);
    hrd("R7", 23);
    // R6: mask gating of latched bits
    hrd("R6", 5);
    hwr("R6", 16, 16'h0000);
    hrd("R6", 20);
    hwr("R6", 16, 16'h00F0);
    hwr("R5", 20, 16'hFFFF);
    // R8: set and clear same bit same cycle
    step("R8", 1, 0, 6, 0, 1, 1, 20, 16'h0040);
    hrd("R8", 20);
    hwr("R8", 20, 16'h0040);
    // R9: both ports write same mailbox and same mask
    hwr("R9", 17, 16'h0100);
    lwr("R9", 19, 16'h0100);
    step("R9", 1, 1, 8, 8'hAA, 1, 1, 8, 8'h55);
    hrd("R9", 8);
    hrd("R9", 22);
    hrd("R9", 23);
    step("R9", 1, 1, 18, 16'h1111, 1, 1, 18, 16'h2222);
    hrd("R9", 18);
    // R10: unused addresses
    hwr("R10", 25, 16'hFFFF);
    lwr("R10", 31, 16'hFFFF);
    for (int a = 24; a < 32; a++) hrd("R10", a);
    for (int a = 0; a < 24; a++) hrd("R10", a);
    // R6: random mixed traffic on both ports
    for (int k = 0; k < 3000; k++) begin
      int ha = $urandom_range(0, 27), la = $urandom_range(0, 27);
      int hd = $urandom_range(0, 65535), ld = $urandom_range(0, 65535);
      if (ha >= 20 && ha < 24) hd &= $urandom_range(0, 65535);
      if (la >= 20 && la < 24) ld &= $urandom_range(0, 65535);
      if ($urandom_range(0, 3) == 0) la = ha;
      step("R6", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ha, hd,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), la, ld);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule